// File: doc/BRIEF.md
# 8-bit Compare Timer with PWM Output

This block is an 8-bit timer/counter with a single compare channel. It moves one step on each cycle where the `tick` clock-enable input is high. That input comes from a prescaler outside the block. A 2-bit mode field picks the counting pattern: a free-running up count, an auto-reload count that clears on compare, a phase-correct up/down PWM, or a fast single-slope PWM. One output pin is driven from compare events. A 2-bit action field chooses what a compare does to that pin.

Software reaches the block through write strobes for the control word, the counter and the compare value. Each of these can also be read back. The block has an overflow flag and a compare flag. Each flag has an enable bit and an acknowledge input, and the two interrupt requests are gated by a global enable. A force strobe inside the control word applies the output action at once, without a real compare. A write to the counter suppresses the compare on the tick that follows, so a freshly loaded value never fires a spurious match.

Top module: `cmp_timer8`

## Requirements
- R1: After synchronous reset, the counter, compare value, control readback, both flags, the pin and both interrupt requests are 0, and the count direction is up.
- R2: Mode 0 (normal) adds 1 on each tick and wraps from 0xFF to 0x00. It sets the overflow flag (flag bit 0) on the wrapping tick. With no tick and no counter write, the count holds.
- R3: Mode 2 (clear on compare) loads 0 on the tick where the count equals the compare value; other ticks add 1.
- R4: Mode 1 (phase-correct PWM) counts up to 0xFF, then down to 0x00, then up again. The overflow flag is set only on the tick that turns the count at 0x00, never at the 0xFF turn.
- R5: Mode 3 (fast PWM) counts up and wraps at 0xFF, setting the overflow flag on the wrap.
- R6: The compare flag (flag bit 1) is set on any tick where the count equals the active compare value.
- R7: Writing 1 to a flag bit through the clear strobe clears that flag, and writing 0 leaves it unchanged. An acknowledge pulse also clears the flag. A set event in the same cycle wins over a clear.
- R8: Interrupt request bit i is high exactly when the global enable, enable bit i and flag bit i are all 1 (bit 0 overflow, bit 1 compare).
- R9: Control word layout: bit 7 is force, mode = {bit 3, bit 6}, the output action is bits 5:4, and clock select is bits 2:0. Everything except bit 7 reads back as written; bit 7 always reads 0.
- R10: In modes 0 and 2, output action 00 holds the pin low (disconnected), 01 toggles it on a match, 10 clears it on a match, and 11 sets it on a match.
- R11: In phase-correct mode, action 10 clears the pin on a match while counting up and sets it on a match while counting down; 11 does the reverse. In fast mode, 10 sets the pin on the wrap and clears it on a match; 11 does the reverse, and the wrap wins if both happen on the same tick. Action 01 or 00 leaves the pin low in both PWM modes.
- R12: A control write with bit 7 set, whose mode is 0 or 2, applies its action field to the pin on that write. It sets no flag and leaves the counter unchanged. In PWM modes the force has no effect.
- R13: In PWM modes, a compare write goes to a buffer that reads back at once. The active compare value loads from that buffer only on the tick taken at 0xFF. In modes 0 and 2 the write takes effect on the next cycle.
- R14: A counter write suppresses any compare match on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_q | output | 8 | Control word readback |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_q | output | CNT_W | Current count |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| cmp_q | output | CNT_W | Buffered compare value readback |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | 2 | Flags to clear (1 = clear) |
| irq_ack | input | 2 | Interrupt acknowledge per source |
| irq_en | input | 2 | Interrupt enable per source |
| gie | input | 1 | Global interrupt enable |
| flags_q | output | 2 | Flags: bit 0 overflow, bit 1 compare |
| irq | output | 2 | Interrupt requests per source |
| cmp_out | output | 1 | Compare output pin |

## Verification
The bench builds the block with the default CNT_W of 8, so the 0xFF turn, the wrap and the 0x00 bottom turn are each a counter write plus a few ticks away. A table of clear-on-compare cases covers a compare value of 0, small and large periods, and runs shorter than one period. Directed tests then cover both PWM slopes with their direction-dependent pin actions, the buffered compare load at the top, match suppression after a counter write, the force strobe in both kinds of mode, and the priority of a set over a clear on the flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PCPWM  = 2'b01,
        MODE_CTC    = 2'b10,
        MODE_FAST   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        COM_OFF    = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_CLEAR  = 2'b10,
        COM_SET    = 2'b11
    } tmr_com_e;

    typedef struct packed {
        logic      force_cmp;
        tmr_mode_e mode;
        tmr_com_e  com;
        logic [2:0] clk_sel;
    } tmr_ctrl_t;

    localparam int NUM_SRC  = 2;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_CMP = 1;

    // mode low bit sits at bit 6, high bit at bit 3
    function automatic tmr_ctrl_t decode_ctrl(input logic [7:0] w);
        tmr_ctrl_t c;
        c.force_cmp = w[7];
        c.mode      = tmr_mode_e'({w[3], w[6]});
        c.com       = tmr_com_e'(w[5:4]);
        c.clk_sel   = w[2:0];
        return c;
    endfunction

    function automatic logic [7:0] encode_ctrl(input tmr_ctrl_t c);
        return {c.force_cmp, c.mode[0], c.com, c.mode[1], c.clk_sel};
    endfunction

    function automatic logic mode_is_pwm(input tmr_mode_e m);
        return (m == MODE_PCPWM) || (m == MODE_FAST);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] ocr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dir_down,
    output logic             advance,
    output logic             at_top,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] TOP    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOTTOM = '0;

    logic [CNT_W-1:0] cnt_n;
    logic             dir_n;

    assign advance = tick && !cnt_we;
    assign at_top  = advance && (cnt_q == TOP);

    always_comb begin
        cnt_n   = cnt_q;
        dir_n   = (mode == MODE_PCPWM) ? dir_down : 1'b0;
        ovf_evt = 1'b0;
        if (cnt_we) begin
            cnt_n = cnt_wdata;
        end else if (advance) begin
            case (mode)
                MODE_CTC: begin
                    cnt_n   = (cnt_q == ocr) ? BOTTOM : cnt_q + 1'b1;
                    ovf_evt = (cnt_q == TOP);
                end
                MODE_PCPWM: begin
                    if (!dir_down) begin
                        if (cnt_q == TOP) begin
                            dir_n = 1'b1;
                            cnt_n = cnt_q - 1'b1;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == BOTTOM) begin
                            dir_n   = 1'b0;
                            cnt_n   = cnt_q + 1'b1;
                            ovf_evt = 1'b1;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_n   = cnt_q + 1'b1;
                    ovf_evt = (cnt_q == TOP);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= BOTTOM;
            dir_down <= 1'b0;
        end else begin
            cnt_q    <= cnt_n;
            dir_down <= dir_n;
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(cnt_q)); // R2

    AST_CTC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (advance && mode == MODE_CTC && cnt_q == ocr) |=> (cnt_q == BOTTOM)); // R3

    AST_PC_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && mode == MODE_PCPWM) |=> (cnt_q == CNT_W'(1) && !dir_down)); // R4

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm,
    input  logic             advance,
    input  logic             at_top,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] ocr_act,
    output logic             match_evt
);
    logic             block_q;
    logic [CNT_W-1:0] buf_n;

    assign buf_n     = cmp_we ? cmp_wdata : cmp_buf;
    assign match_evt = advance && !block_q && (cnt_q == ocr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf <= '0;
            ocr_act <= '0;
            block_q <= 1'b0;
        end else begin
            cmp_buf <= buf_n;
            if (!pwm || at_top)
                ocr_act <= buf_n;
            if (cnt_we)
                block_q <= 1'b1;
            else if (advance)
                block_q <= 1'b0;
        end
    end

    AST_WRITE_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> !match_evt); // R14

    AST_PWM_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwm && !at_top) |=> $stable(ocr_act)); // R13

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  tmr_com_e  com,
    input  logic      match_evt,
    input  logic      dir_down,
    input  logic      wrap_evt,
    input  logic      force_evt,
    input  tmr_com_e  force_com,
    output logic      cmp_out
);
    logic pin_q, pin_n, connected;

    always_comb begin
        pin_n = pin_q;
        if (force_evt) begin
            case (force_com)
                COM_TOGGLE: pin_n = !pin_q;
                COM_CLEAR:  pin_n = 1'b0;
                COM_SET:    pin_n = 1'b1;
                default:    pin_n = pin_q;
            endcase
        end else if (!mode_is_pwm(mode)) begin
            if (match_evt) begin
                case (com)
                    COM_TOGGLE: pin_n = !pin_q;
                    COM_CLEAR:  pin_n = 1'b0;
                    COM_SET:    pin_n = 1'b1;
                    default:    pin_n = pin_q;
                endcase
            end
        end else if (mode == MODE_FAST) begin
            if (wrap_evt) begin
                if (com == COM_CLEAR)    pin_n = 1'b1;
                else if (com == COM_SET) pin_n = 1'b0;
            end else if (match_evt) begin
                if (com == COM_CLEAR)    pin_n = 1'b0;
                else if (com == COM_SET) pin_n = 1'b1;
            end
        end else if (match_evt) begin
            if (com == COM_CLEAR)    pin_n = dir_down;
            else if (com == COM_SET) pin_n = !dir_down;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_n;
    end

    assign connected = mode_is_pwm(mode) ? (com == COM_CLEAR || com == COM_SET)
                                         : (com != COM_OFF);
    assign cmp_out = connected && pin_q;

    AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_pwm(mode) && com == COM_TOGGLE && match_evt && !force_evt)
        |=> (pin_q != $past(pin_q))); // R10

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_evt,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_data,
    input  logic [NSRC-1:0] ack,
    input  logic [NSRC-1:0] en,
    input  logic            gie,
    output logic [NSRC-1:0] flag_q,
    output logic [NSRC-1:0] irq
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic clr_i;
        assign clr_i = (clr_we && clr_data[i]) || ack[i];

        always_ff @(posedge clk) begin
            if (rst)             flag_q[i] <= 1'b0;
            else if (set_evt[i]) flag_q[i] <= 1'b1;
            else if (clr_i)      flag_q[i] <= 1'b0;
        end

        assign irq[i] = gie && en[i] && flag_q[i];

        AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> flag_q[i]); // R7

        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !set_evt[i]) |=> !flag_q[i]); // R7
    end

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_q,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_q,
    input  logic             flag_clr_we,
    input  logic [1:0]       flag_clr_data,
    input  logic [1:0]       irq_ack,
    input  logic [1:0]       irq_en,
    input  logic             gie,
    output logic [1:0]       flags_q,
    output logic [1:0]       irq,
    output logic             cmp_out
);
    tmr_ctrl_t        ctrl_r, wr_dec;
    logic             force_evt, dir_down, advance, at_top, ovf_evt, match_evt, wrap_evt;
    logic [CNT_W-1:0] ocr_act;
    logic [NUM_SRC-1:0] set_evt;

    assign wr_dec    = decode_ctrl(ctrl_wdata);
    assign force_evt = ctrl_we && wr_dec.force_cmp && !mode_is_pwm(wr_dec.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= tmr_ctrl_t'('0);
        end else if (ctrl_we) begin
            ctrl_r           <= wr_dec;
            ctrl_r.force_cmp <= 1'b0;
        end
    end
    assign ctrl_q = encode_ctrl(ctrl_r);

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick), .mode(ctrl_r.mode),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ocr(ocr_act),
        .cnt_q(cnt_q), .dir_down(dir_down), .advance(advance),
        .at_top(at_top), .ovf_evt(ovf_evt)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_compare (
        .clk(clk), .rst(rst), .pwm(mode_is_pwm(ctrl_r.mode)),
        .advance(advance), .at_top(at_top), .cnt_we(cnt_we),
        .cnt_q(cnt_q), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .cmp_buf(cmp_q), .ocr_act(ocr_act), .match_evt(match_evt)
    );

    assign wrap_evt = at_top && (ctrl_r.mode == MODE_FAST);

    tmr_wave u_wave (
        .clk(clk), .rst(rst), .mode(ctrl_r.mode), .com(ctrl_r.com),
        .match_evt(match_evt), .dir_down(dir_down), .wrap_evt(wrap_evt),
        .force_evt(force_evt), .force_com(wr_dec.com), .cmp_out(cmp_out)
    );

    assign set_evt[FLAG_OVF] = ovf_evt;
    assign set_evt[FLAG_CMP] = match_evt;

    tmr_flags #(.NSRC(NUM_SRC)) u_flags (
        .clk(clk), .rst(rst), .set_evt(set_evt), .clr_we(flag_clr_we),
        .clr_data(flag_clr_data), .ack(irq_ack), .en(irq_en), .gie(gie),
        .flag_q(flags_q), .irq(irq)
    );

    AST_FORCE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (force_evt && !tick && !cnt_we) |=> $stable(cnt_q)); // R12

endmodule

// File: tb/cmp_timer8_bench.sv
module cmp_timer8_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b0, tick = 1'b0;
    logic       ctrl_we = 1'b0, cnt_we = 1'b0, cmp_we = 1'b0, flag_clr_we = 1'b0, gie = 1'b0;
    logic [7:0] ctrl_wdata = '0, cnt_wdata = '0, cmp_wdata = '0;
    logic [1:0] flag_clr_data = '0, irq_ack = '0, irq_en = '0;
    logic [7:0] ctrl_q, cnt_q, cmp_q;
    logic [1:0] flags_q, irq;
    logic       cmp_out;

    int n_run = 0, n_fail = 0, cyc_cnt = 0;

    always #5 clk = ~clk;

    cmp_timer8 u_cmp_timer8 (
        .clk(clk), .rst(rst), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_q(cmp_q),
        .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
        .irq_ack(irq_ack), .irq_en(irq_en), .gie(gie),
        .flags_q(flags_q), .irq(irq), .cmp_out(cmp_out)
    );

    typedef struct packed {
        logic [7:0] cmp;
        logic [7:0] nticks;
        logic [7:0] exp_cnt;
        logic       exp_flag;
    } vec_t;

    // clear-on-compare cases: count = nticks mod (cmp+1), flag once count hit cmp
    localparam vec_t VEC [8] = '{
        '{8'd5,   8'd3,  8'd3,  1'b0},
        '{8'd5,   8'd6,  8'd0,  1'b1},
        '{8'd5,   8'd7,  8'd1,  1'b1},
        '{8'd3,   8'd9,  8'd1,  1'b1},
        '{8'd0,   8'd5,  8'd0,  1'b1},
        '{8'd200, 8'd10, 8'd10, 1'b0},
        '{8'd1,   8'd4,  8'd0,  1'b1},
        '{8'd2,   8'd8,  8'd2,  1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk); #1;
        tick = 1'b0; ctrl_we = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0;
        flag_clr_we = 1'b0; irq_ack = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc(1'b0); cyc(1'b0); rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v); ctrl_we = 1'b1; ctrl_wdata = v; cyc(1'b0); endtask
    task automatic wr_cnt (input logic [7:0] v); cnt_we  = 1'b1; cnt_wdata  = v; cyc(1'b0); endtask
    task automatic wr_cmp (input logic [7:0] v); cmp_we  = 1'b1; cmp_wdata  = v; cyc(1'b0); endtask
    task automatic clr_flags(input logic [1:0] d); flag_clr_we = 1'b1; flag_clr_data = d; cyc(1'b0); endtask
    task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(1'b1); endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc_cnt);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        // R1 reset state
        do_reset();
        gie = 1'b1; irq_en = 2'b11; #1;
        chk("R1 cnt", cnt_q, 8'h00);
        chk("R1 cmp", cmp_q, 8'h00);
        chk("R1 ctrl", ctrl_q, 8'h00);
        chk("R1 flags", flags_q, 2'b00);
        chk("R1 pin", cmp_out, 1'b0);
        chk("R1 irq", irq, 2'b00);
        gie = 1'b0; irq_en = 2'b00;

        // R3 R6 table of clear-on-compare runs
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr_ctrl(8'h08);
            wr_cmp(VEC[i].cmp);
            ticks(int'(VEC[i].nticks));
            chk($sformatf("R3 vec%0d count", i), cnt_q, VEC[i].exp_cnt);
            chk($sformatf("R6 vec%0d cmp flag", i), flags_q[1], VEC[i].exp_flag);
            chk($sformatf("R3 vec%0d no ovf", i), flags_q[0], 1'b0);
        end

        // R2 normal count, hold, wrap
        do_reset();
        wr_cnt(8'hFD);
        cyc(1'b0); cyc(1'b0);
        chk("R2 hold", cnt_q, 8'hFD);
        ticks(2);
        chk("R2 count FF", cnt_q, 8'hFF);
        chk("R2 no ovf yet", flags_q[0], 1'b0);
        ticks(1);
        chk("R2 wrap", cnt_q, 8'h00);
        chk("R2 ovf set", flags_q[0], 1'b1);

        // R8 interrupt gating
        irq_en = 2'b01; #1;
        chk("R8 gie off", irq, 2'b00);
        gie = 1'b1; #1;
        chk("R8 all on", irq, 2'b01);
        irq_en = 2'b00; #1;
        chk("R8 enable off", irq, 2'b00);
        irq_en = 2'b01;

        // R7 flag clearing
        clr_flags(2'b00);
        chk("R7 zero write keeps", flags_q[0], 1'b1);
        clr_flags(2'b10);
        chk("R7 other bit keeps", flags_q[0], 1'b1);
        irq_ack = 2'b01; cyc(1'b0);
        chk("R7 ack clears", flags_q[0], 1'b0);
        chk("R8 irq drops", irq[0], 1'b0);
        wr_cnt(8'hFF);
        flag_clr_we = 1'b1; flag_clr_data = 2'b01; cyc(1'b1);
        chk("R7 set wins", flags_q[0], 1'b1);
        clr_flags(2'b01);
        chk("R7 write one clears", flags_q[0], 1'b0);

        // R14 match blocked after counter write
        wr_cmp(8'h10);
        clr_flags(2'b11);
        wr_cnt(8'h10);
        ticks(1);
        chk("R14 blocked match", flags_q[1], 1'b0);
        chk("R14 count moved", cnt_q, 8'h11);
        wr_cnt(8'h0F);
        ticks(2);
        chk("R6 later match", flags_q[1], 1'b1);

        // R10 R12 non-PWM outputs and force
        wr_ctrl(8'h30);
        wr_cmp(8'h21);
        wr_cnt(8'h20);
        clr_flags(2'b11);
        ticks(2);
        chk("R10 set on match", cmp_out, 1'b1);
        clr_flags(2'b10);
        wr_ctrl(8'hA0);
        chk("R12 force clears", cmp_out, 1'b0);
        chk("R12 no flag", flags_q[1], 1'b0);
        chk("R12 count kept", cnt_q, 8'h22);
        chk("R9 force reads 0", ctrl_q, 8'h20);
        wr_ctrl(8'h10);
        wr_cnt(8'h20);
        ticks(2);
        chk("R10 toggle on match", cmp_out, 1'b1);
        wr_ctrl(8'h90);
        chk("R12 force toggle", cmp_out, 1'b0);
        wr_ctrl(8'hB0);
        chk("R12 force set", cmp_out, 1'b1);
        wr_ctrl(8'h00);
        chk("R10 disconnected low", cmp_out, 1'b0);
        wr_ctrl(8'h20);
        chk("R10 reconnected", cmp_out, 1'b1);
        wr_cnt(8'h20);
        ticks(2);
        chk("R10 clear on match", cmp_out, 1'b0);

        // R4 R11 R13 phase-correct PWM
        do_reset();
        gie = 1'b0; irq_en = 2'b00;
        wr_cmp(8'h80);
        wr_ctrl(8'h60);
        chk("R9 readback", ctrl_q, 8'h60);
        wr_cnt(8'hFD);
        ticks(3);
        chk("R4 top turn", cnt_q, 8'hFE);
        chk("R4 no ovf at top", flags_q[0], 1'b0);
        wr_cnt(8'h81);
        ticks(2);
        chk("R11 down match sets", cmp_out, 1'b1);
        chk("R4 counting down", cnt_q, 8'h7F);
        wr_cnt(8'h02);
        ticks(2);
        chk("R4 at bottom", cnt_q, 8'h00);
        chk("R4 no ovf before turn", flags_q[0], 1'b0);
        ticks(1);
        chk("R4 bottom turn", cnt_q, 8'h01);
        chk("R4 ovf at bottom", flags_q[0], 1'b1);
        wr_cnt(8'h7F);
        ticks(2);
        chk("R11 up match clears", cmp_out, 1'b0);
        wr_cmp(8'h40);
        chk("R13 buffer readback", cmp_q, 8'h40);
        clr_flags(2'b11);
        wr_cnt(8'h3F);
        ticks(2);
        chk("R13 old value active", flags_q[1], 1'b0);
        wr_cnt(8'hFE);
        ticks(2);
        wr_cnt(8'h41);
        ticks(2);
        chk("R13 loaded at top", flags_q[1], 1'b1);
        chk("R11 down match sets again", cmp_out, 1'b1);

        // R5 R11 R12 fast PWM
        do_reset();
        wr_cmp(8'h10);
        wr_ctrl(8'h68);
        wr_cnt(8'hFE);
        ticks(1);
        chk("R5 before wrap", flags_q[0], 1'b0);
        ticks(1);
        chk("R5 wrap", cnt_q, 8'h00);
        chk("R5 ovf on wrap", flags_q[0], 1'b1);
        chk("R11 set on wrap", cmp_out, 1'b1);
        wr_cnt(8'h0F);
        ticks(2);
        chk("R11 clear on match", cmp_out, 1'b0);
        chk("R5 count", cnt_q, 8'h11);
        wr_ctrl(8'hE8);
        chk("R12 force ignored in PWM", cmp_out, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule